// File: doc/BRIEF.md
# Execute-Group Redirect and Writeback Slotter

Each cycle the issue stage hands this block a group of up to `ISSUE_W` instruction slots. The block scans the group in slot order and decides which slots are taken into execute. The scan halts at the first empty slot, or once the number of non-squashed instructions taken reaches `EXEC_W`. Squashed instructions are taken as already executed and use no execute bandwidth.

Every taken instruction, squashed or not, is written into a writeback buffer. The buffer has `WB_ROWS` time rows of `WB_PORTS` positions each. An instruction goes into the first free position, searching row by row, after the buffer has advanced by one row. Row 0 is presented to commit each cycle. When no position is left, the instruction is dropped and an overflow flag is raised.

From the taken, non-squashed instructions the block chooses at most one fetch-redirect cause per group. The cause is either a branch mispredict or a memory-order violation reported for that slot by the load/store queue. The block then emits a registered squash message for commit. For a memory-order violation it also sends a notification to the instruction queue. Event counters keep running totals of the group results.

Top module: `exec_group_slotter`

## Requirements
- R1: While `rst_n` is low, every output is zero: commit valids, redirect message, queue notification, overflow flag and all counters.
- R2: `acc_o` is a contiguous prefix of the group. The scan stops at the first slot whose `slot_vld_i` bit is 0, so no slot after it is taken, even if that later slot is valid.
- R3: At most `EXEC_W` (default 3) non-squashed slots are taken per group. Squashed slots (`slot_sq_i`=1) are taken without counting toward that limit, and a slot is refused once the limit is already used.
- R4: Taken slots enter the writeback buffer in slot order, and each goes to the first free position in row-major order. Commit therefore sees entries in acceptance order, at most `WB_PORTS` per cycle. An entry shows on `commit_vld_o`/`commit_seq_o`/`commit_sq_o` in the cycle after acceptance when row 0 has room. Commit lane 0 fills before lane 1.
- R5: A taken slot that finds all `WB_ROWS*WB_PORTS` positions occupied is dropped, and entries already held are kept. `wb_ovf_o` is 1 in the cycle after such a group.
- R6: Only the first redirect cause among taken, non-squashed slots in slot order is honoured. Within one slot, a mispredict wins over a violation. Squashed slots and untaken slots never redirect.
- R7: For a branch redirect, in the cycle after the group, `rd_vld_o`=1 and `rd_misp_o`=1. `rd_seq_o`, `rd_pc_o` and `rd_npc_o` come from the chosen slot. `rd_taken_o` = (npc != pc + 4). `iqv_vld_o`=0.
- R8: For a memory-order redirect, `rd_vld_o`=1 with the chosen slot's sequence number and next PC. `rd_pc_o`, `rd_misp_o` and `rd_taken_o` are 0. `iqv_vld_o`=1, carrying the chosen slot's sequence number on `iqv_seq_o` and its violator tag on `iqv_tag_o`.
- R9: The counters add, per group, the taken non-squashed loads (`slot_mem_i`&`slot_ld_i`) and stores (`slot_mem_i`&`slot_st_i`, not load). They also add the taken non-memory instructions, the taken squashed slots, and the honoured memory-order redirects. The last counter adds honoured branch redirects whose `slot_ptk_i` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_vld_i | input | ISSUE_W | Slot holds an instruction |
| slot_sq_i | input | ISSUE_W | Instruction is already squashed |
| slot_mem_i | input | ISSUE_W | Memory reference |
| slot_ld_i | input | ISSUE_W | Memory reference is a load |
| slot_st_i | input | ISSUE_W | Memory reference is a store |
| slot_misp_i | input | ISSUE_W | Branch resolved as mispredicted |
| slot_ptk_i | input | ISSUE_W | Branch had been predicted taken |
| slot_viol_i | input | ISSUE_W | Load/store queue reports an order violation |
| slot_pc_i | input | ISSUE_W x PC_W | PC per slot |
| slot_npc_i | input | ISSUE_W x PC_W | Resolved next PC per slot |
| slot_seq_i | input | ISSUE_W x SEQ_W | Sequence number per slot |
| slot_vtag_i | input | ISSUE_W x SEQ_W | Violating instruction tag per slot |
| acc_o | output | ISSUE_W | Slots taken this cycle (combinational) |
| commit_vld_o | output | WB_PORTS | Writeback row 0 entry valid |
| commit_sq_o | output | WB_PORTS | Entry was squashed |
| commit_seq_o | output | WB_PORTS x SEQ_W | Entry sequence number |
| wb_ovf_o | output | 1 | An instruction found no writeback position |
| rd_vld_o | output | 1 | Squash message valid |
| rd_seq_o | output | SEQ_W | Squashing instruction sequence number |
| rd_pc_o | output | PC_W | Mispredicted PC (branch only) |
| rd_npc_o | output | PC_W | Corrected next PC |
| rd_misp_o | output | 1 | Redirect is a branch mispredict |
| rd_taken_o | output | 1 | Corrected branch direction |
| iqv_vld_o | output | 1 | Order-violation notice to the instruction queue |
| iqv_seq_o | output | SEQ_W | Instruction that detected the violation |
| iqv_tag_o | output | SEQ_W | Violating instruction tag |
| cnt_ld_o | output | CNT_W | Loads executed |
| cnt_st_o | output | CNT_W | Stores executed |
| cnt_alu_o | output | CNT_W | Non-memory instructions executed |
| cnt_sqskip_o | output | CNT_W | Squashed instructions passed through |
| cnt_viol_o | output | CNT_W | Memory-order redirects |
| cnt_ptk_o | output | CNT_W | Mispredicts that were predicted taken |

## Verification
The bench drives several group shapes, and each one separates a different scan rule. Full groups check the execute limit. Groups that mix in squashed slots show that squashed instructions take no execute bandwidth. A hole early in the group checks the stop-at-empty rule. Redirect patterns that place a mispredict and a violation in different orders, in the same slot, on a squashed slot, or beyond the accepted prefix confirm the choice rule and the message fields. A taken and a fall-through next PC both appear, so the direction bit is checked in both values. A run of wide groups that outpaces the two commit lanes fills the buffer until it overflows, then drains it, which checks in-order placement and the drop-on-full behaviour against a scoreboard of expected commit entries.

// File: rtl/exg_pkg.sv
package exg_pkg;
    typedef enum logic [1:0] {
        RD_NONE   = 2'd0,
        RD_BRANCH = 2'd1,
        RD_MEMORD = 2'd2
    } rd_kind_e;
endpackage

// File: rtl/exg_scan.sv
module exg_scan
    import exg_pkg::*;
#(
    parameter int ISSUE_W = 4,
    parameter int EXEC_W  = 3,
    localparam int IC_W   = $clog2(ISSUE_W + 1),
    localparam int IDX_W  = (ISSUE_W > 1) ? $clog2(ISSUE_W) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ISSUE_W-1:0] vld_i,
    input  logic [ISSUE_W-1:0] sq_i,
    input  logic [ISSUE_W-1:0] mem_i,
    input  logic [ISSUE_W-1:0] ld_i,
    input  logic [ISSUE_W-1:0] st_i,
    input  logic [ISSUE_W-1:0] misp_i,
    input  logic [ISSUE_W-1:0] ptk_i,
    input  logic [ISSUE_W-1:0] viol_i,
    output logic [ISSUE_W-1:0] acc_o,
    output rd_kind_e           kind_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic               ptk_hit_o,
    output logic [IC_W-1:0]    n_ld_o,
    output logic [IC_W-1:0]    n_st_o,
    output logic [IC_W-1:0]    n_alu_o,
    output logic [IC_W-1:0]    n_sq_o
);
    logic [IC_W-1:0] used;
    logic            halted;

    always_comb begin
        acc_o     = '0;
        kind_o    = RD_NONE;
        idx_o     = '0;
        ptk_hit_o = 1'b0;
        n_ld_o    = '0;
        n_st_o    = '0;
        n_alu_o   = '0;
        n_sq_o    = '0;
        used      = '0;
        halted    = 1'b0;
        for (int k = 0; k < ISSUE_W; k++) begin
            if (!halted) begin
                if (!vld_i[k] || used == IC_W'(EXEC_W)) begin
                    halted = 1'b1;
                end else begin
                    acc_o[k] = 1'b1;
                    if (sq_i[k]) begin
                        n_sq_o = n_sq_o + IC_W'(1);
                    end else begin
                        used = used + IC_W'(1);
                        if (!mem_i[k])
                            n_alu_o = n_alu_o + IC_W'(1);
                        else if (ld_i[k])
                            n_ld_o = n_ld_o + IC_W'(1);
                        else if (st_i[k])
                            n_st_o = n_st_o + IC_W'(1);
                        if (kind_o == RD_NONE) begin
                            if (misp_i[k]) begin
                                kind_o    = RD_BRANCH;
                                idx_o     = IDX_W'(k);
                                ptk_hit_o = ptk_i[k];
                            end else if (viol_i[k]) begin
                                kind_o = RD_MEMORD;
                                idx_o  = IDX_W'(k);
                            end
                        end
                    end
                end
            end
        end
    end

    // R3
    exec_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(acc_o & ~sq_i) <= EXEC_W);

    // R2
    generate
        for (genvar g = 1; g < ISSUE_W; g++) begin : g_pref
            acc_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
                acc_o[g] |-> (acc_o[g-1] && vld_i[g-1]));
        end
    endgenerate
endmodule

// File: rtl/exg_wbslot.sv
module exg_wbslot #(
    parameter int ISSUE_W  = 4,
    parameter int WB_PORTS = 2,
    parameter int WB_ROWS  = 5,
    parameter int SEQ_W    = 16,
    localparam int NPOS    = WB_PORTS * WB_ROWS
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ISSUE_W-1:0]             acc_i,
    input  logic [ISSUE_W-1:0]             sq_i,
    input  logic [ISSUE_W-1:0][SEQ_W-1:0]  seq_i,
    output logic [WB_PORTS-1:0]            commit_vld_o,
    output logic [WB_PORTS-1:0]            commit_sq_o,
    output logic [WB_PORTS-1:0][SEQ_W-1:0] commit_seq_o,
    output logic                           wb_ovf_o
);
    logic [NPOS-1:0]            v_q, v_d, sq_q, sq_d;
    logic [NPOS-1:0][SEQ_W-1:0] seq_q, seq_d;
    logic                       ovf_d, placed;

    always_comb begin
        for (int p = 0; p < NPOS; p++) begin
            if (p + WB_PORTS < NPOS) begin
                v_d[p]   = v_q[p+WB_PORTS];
                sq_d[p]  = sq_q[p+WB_PORTS];
                seq_d[p] = seq_q[p+WB_PORTS];
            end else begin
                v_d[p]   = 1'b0;
                sq_d[p]  = 1'b0;
                seq_d[p] = '0;
            end
        end
        ovf_d  = 1'b0;
        placed = 1'b0;
        for (int k = 0; k < ISSUE_W; k++) begin
            if (acc_i[k]) begin
                placed = 1'b0;
                for (int p = 0; p < NPOS; p++) begin
                    if (!placed && !v_d[p]) begin
                        v_d[p]   = 1'b1;
                        sq_d[p]  = sq_i[k];
                        seq_d[p] = seq_i[k];
                        placed   = 1'b1;
                    end
                end
                if (!placed)
                    ovf_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q      <= '0;
            sq_q     <= '0;
            seq_q    <= '0;
            wb_ovf_o <= 1'b0;
        end else begin
            v_q      <= v_d;
            sq_q     <= sq_d;
            seq_q    <= seq_d;
            wb_ovf_o <= ovf_d;
        end
    end

    always_comb begin
        for (int c = 0; c < WB_PORTS; c++) begin
            commit_vld_o[c] = v_q[c];
            commit_sq_o[c]  = sq_q[c];
            commit_seq_o[c] = seq_q[c];
        end
    end

    // R5
    ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ovf_o |-> (&commit_vld_o));

    // R4
    generate
        for (genvar g = 1; g < WB_PORTS; g++) begin : g_lane
            lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                commit_vld_o[g] |-> commit_vld_o[g-1]);
        end
    endgenerate
endmodule

// File: rtl/exg_counters.sv
module exg_counters #(
    parameter int CNT_W = 16,
    parameter int IC_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IC_W-1:0]  inc_ld_i,
    input  logic [IC_W-1:0]  inc_st_i,
    input  logic [IC_W-1:0]  inc_alu_i,
    input  logic [IC_W-1:0]  inc_sq_i,
    input  logic             inc_viol_i,
    input  logic             inc_ptk_i,
    output logic [CNT_W-1:0] cnt_ld_o,
    output logic [CNT_W-1:0] cnt_st_o,
    output logic [CNT_W-1:0] cnt_alu_o,
    output logic [CNT_W-1:0] cnt_sq_o,
    output logic [CNT_W-1:0] cnt_viol_o,
    output logic [CNT_W-1:0] cnt_ptk_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_ld_o   <= '0;
            cnt_st_o   <= '0;
            cnt_alu_o  <= '0;
            cnt_sq_o   <= '0;
            cnt_viol_o <= '0;
            cnt_ptk_o  <= '0;
        end else begin
            cnt_ld_o   <= cnt_ld_o   + CNT_W'(inc_ld_i);
            cnt_st_o   <= cnt_st_o   + CNT_W'(inc_st_i);
            cnt_alu_o  <= cnt_alu_o  + CNT_W'(inc_alu_i);
            cnt_sq_o   <= cnt_sq_o   + CNT_W'(inc_sq_i);
            cnt_viol_o <= cnt_viol_o + CNT_W'(inc_viol_i);
            cnt_ptk_o  <= cnt_ptk_o  + CNT_W'(inc_ptk_i);
        end
    end
endmodule

// File: rtl/exec_group_slotter.sv
module exec_group_slotter
    import exg_pkg::*;
#(
    parameter int ISSUE_W  = 4,
    parameter int EXEC_W   = 3,
    parameter int WB_PORTS = 2,
    parameter int WB_ROWS  = 5,
    parameter int PC_W     = 32,
    parameter int SEQ_W    = 16,
    parameter int CNT_W    = 16,
    parameter int INST_B   = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ISSUE_W-1:0]             slot_vld_i,
    input  logic [ISSUE_W-1:0]             slot_sq_i,
    input  logic [ISSUE_W-1:0]             slot_mem_i,
    input  logic [ISSUE_W-1:0]             slot_ld_i,
    input  logic [ISSUE_W-1:0]             slot_st_i,
    input  logic [ISSUE_W-1:0]             slot_misp_i,
    input  logic [ISSUE_W-1:0]             slot_ptk_i,
    input  logic [ISSUE_W-1:0]             slot_viol_i,
    input  logic [ISSUE_W-1:0][PC_W-1:0]   slot_pc_i,
    input  logic [ISSUE_W-1:0][PC_W-1:0]   slot_npc_i,
    input  logic [ISSUE_W-1:0][SEQ_W-1:0]  slot_seq_i,
    input  logic [ISSUE_W-1:0][SEQ_W-1:0]  slot_vtag_i,
    output logic [ISSUE_W-1:0]             acc_o,
    output logic [WB_PORTS-1:0]            commit_vld_o,
    output logic [WB_PORTS-1:0]            commit_sq_o,
    output logic [WB_PORTS-1:0][SEQ_W-1:0] commit_seq_o,
    output logic                           wb_ovf_o,
    output logic                           rd_vld_o,
    output logic [SEQ_W-1:0]               rd_seq_o,
    output logic [PC_W-1:0]                rd_pc_o,
    output logic [PC_W-1:0]                rd_npc_o,
    output logic                           rd_misp_o,
    output logic                           rd_taken_o,
    output logic                           iqv_vld_o,
    output logic [SEQ_W-1:0]               iqv_seq_o,
    output logic [SEQ_W-1:0]               iqv_tag_o,
    output logic [CNT_W-1:0]               cnt_ld_o,
    output logic [CNT_W-1:0]               cnt_st_o,
    output logic [CNT_W-1:0]               cnt_alu_o,
    output logic [CNT_W-1:0]               cnt_sqskip_o,
    output logic [CNT_W-1:0]               cnt_viol_o,
    output logic [CNT_W-1:0]               cnt_ptk_o
);
    localparam int IC_W  = $clog2(ISSUE_W + 1);
    localparam int IDX_W = (ISSUE_W > 1) ? $clog2(ISSUE_W) : 1;

    rd_kind_e         kind;
    logic [IDX_W-1:0] idx;
    logic             ptk_hit;
    logic [IC_W-1:0]  n_ld, n_st, n_alu, n_sq;
    logic [PC_W-1:0]  sel_pc, sel_npc;

    exg_scan #(.ISSUE_W(ISSUE_W), .EXEC_W(EXEC_W)) u_scan (
        .clk(clk), .rst_n(rst_n),
        .vld_i(slot_vld_i), .sq_i(slot_sq_i), .mem_i(slot_mem_i),
        .ld_i(slot_ld_i), .st_i(slot_st_i), .misp_i(slot_misp_i),
        .ptk_i(slot_ptk_i), .viol_i(slot_viol_i),
        .acc_o(acc_o), .kind_o(kind), .idx_o(idx), .ptk_hit_o(ptk_hit),
        .n_ld_o(n_ld), .n_st_o(n_st), .n_alu_o(n_alu), .n_sq_o(n_sq)
    );

    exg_wbslot #(.ISSUE_W(ISSUE_W), .WB_PORTS(WB_PORTS), .WB_ROWS(WB_ROWS),
                 .SEQ_W(SEQ_W)) u_wb (
        .clk(clk), .rst_n(rst_n),
        .acc_i(acc_o), .sq_i(slot_sq_i), .seq_i(slot_seq_i),
        .commit_vld_o(commit_vld_o), .commit_sq_o(commit_sq_o),
        .commit_seq_o(commit_seq_o), .wb_ovf_o(wb_ovf_o)
    );

    exg_counters #(.CNT_W(CNT_W), .IC_W(IC_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .inc_ld_i(n_ld), .inc_st_i(n_st), .inc_alu_i(n_alu), .inc_sq_i(n_sq),
        .inc_viol_i(kind == RD_MEMORD), .inc_ptk_i(kind == RD_BRANCH && ptk_hit),
        .cnt_ld_o(cnt_ld_o), .cnt_st_o(cnt_st_o), .cnt_alu_o(cnt_alu_o),
        .cnt_sq_o(cnt_sqskip_o), .cnt_viol_o(cnt_viol_o), .cnt_ptk_o(cnt_ptk_o)
    );

    assign sel_pc  = slot_pc_i[idx];
    assign sel_npc = slot_npc_i[idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld_o   <= 1'b0;
            rd_seq_o   <= '0;
            rd_pc_o    <= '0;
            rd_npc_o   <= '0;
            rd_misp_o  <= 1'b0;
            rd_taken_o <= 1'b0;
            iqv_vld_o  <= 1'b0;
            iqv_seq_o  <= '0;
            iqv_tag_o  <= '0;
        end else begin
            rd_vld_o   <= 1'b0;
            rd_seq_o   <= '0;
            rd_pc_o    <= '0;
            rd_npc_o   <= '0;
            rd_misp_o  <= 1'b0;
            rd_taken_o <= 1'b0;
            iqv_vld_o  <= 1'b0;
            iqv_seq_o  <= '0;
            iqv_tag_o  <= '0;
            unique case (kind)
                RD_BRANCH: begin
                    rd_vld_o   <= 1'b1;
                    rd_seq_o   <= slot_seq_i[idx];
                    rd_pc_o    <= sel_pc;
                    rd_npc_o   <= sel_npc;
                    rd_misp_o  <= 1'b1;
                    rd_taken_o <= (sel_npc != sel_pc + PC_W'(INST_B));
                end
                RD_MEMORD: begin
                    rd_vld_o  <= 1'b1;
                    rd_seq_o  <= slot_seq_i[idx];
                    rd_npc_o  <= sel_npc;
                    iqv_vld_o <= 1'b1;
                    iqv_seq_o <= slot_seq_i[idx];
                    iqv_tag_o <= slot_vtag_i[idx];
                end
                default: ;
            endcase
        end
    end

    // R8
    viol_notify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iqv_vld_o |-> (rd_vld_o && !rd_misp_o && iqv_seq_o == rd_seq_o));

    // R7
    misp_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_misp_o |-> (rd_vld_o && !iqv_vld_o));
endmodule

// File: tb/exec_group_slotter_bench.sv
module exec_group_slotter_bench;
    localparam int PERIOD = 10;
    localparam int IW = 4;
    localparam int WP = 2;
    localparam int NPOS = 10;
    localparam int EXW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    logic [IW-1:0] vld = '0, sq = '0, mem = '0, ld = '0, st = '0;
    logic [IW-1:0] misp = '0, ptk = '0, viol = '0;
    logic [IW-1:0][31:0] pc = '0, npc = '0;
    logic [IW-1:0][15:0] seq = '0, vtag = '0;

    logic [IW-1:0] acc;
    logic [WP-1:0] c_vld, c_sq;
    logic [WP-1:0][15:0] c_seq;
    logic ovf, rd_vld, rd_misp, rd_taken, iqv_vld;
    logic [15:0] rd_seq, iqv_seq, iqv_tag;
    logic [31:0] rd_pc, rd_npc;
    logic [15:0] c_ld, c_st, c_alu, c_sqs, c_viol, c_ptk;

    exec_group_slotter u_exec_group_slotter (
        .clk(clk), .rst_n(rst_n),
        .slot_vld_i(vld), .slot_sq_i(sq), .slot_mem_i(mem), .slot_ld_i(ld),
        .slot_st_i(st), .slot_misp_i(misp), .slot_ptk_i(ptk), .slot_viol_i(viol),
        .slot_pc_i(pc), .slot_npc_i(npc), .slot_seq_i(seq), .slot_vtag_i(vtag),
        .acc_o(acc), .commit_vld_o(c_vld), .commit_sq_o(c_sq), .commit_seq_o(c_seq),
        .wb_ovf_o(ovf), .rd_vld_o(rd_vld), .rd_seq_o(rd_seq), .rd_pc_o(rd_pc),
        .rd_npc_o(rd_npc), .rd_misp_o(rd_misp), .rd_taken_o(rd_taken),
        .iqv_vld_o(iqv_vld), .iqv_seq_o(iqv_seq), .iqv_tag_o(iqv_tag),
        .cnt_ld_o(c_ld), .cnt_st_o(c_st), .cnt_alu_o(c_alu),
        .cnt_sqskip_o(c_sqs), .cnt_viol_o(c_viol), .cnt_ptk_o(c_ptk)
    );

    int total = 0;
    int bad = 0;
    bit run = 0;
    logic [16:0] sb[$];
    logic [15:0] seq_ctr = 16'h0010;
    logic [31:0] pc_base = 32'h0000_1000;

    logic        e_rd, e_misp, e_taken, e_iqv, e_ovf;
    logic [15:0] e_seq, e_tag;
    logic [31:0] e_pc, e_npc;
    logic [15:0] x_ld = 0, x_st = 0, x_alu = 0, x_sq = 0, x_viol = 0, x_ptk = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] v, input logic [3:0] s, input logic [3:0] m,
                         input logic [3:0] l, input logic [3:0] t, input logic [3:0] mp,
                         input logic [3:0] pt, input logic [3:0] vi, input logic [3:0] tk);
        int used;
        bit stop, found;
        logic [3:0] eacc;
        for (int k = 0; k < IW; k++) begin
            vld[k] = v[k]; sq[k] = s[k]; mem[k] = m[k]; ld[k] = l[k]; st[k] = t[k];
            misp[k] = mp[k]; ptk[k] = pt[k]; viol[k] = vi[k];
            pc[k]   = pc_base + 32'(k * 4);
            npc[k]  = tk[k] ? pc[k] + 32'h40 : pc[k] + 32'd4;
            seq[k]  = seq_ctr;
            vtag[k] = seq_ctr + 16'h0100;
            seq_ctr = seq_ctr + 16'd1;
        end
        pc_base = pc_base + 32'h100;
        used = 0; stop = 0; found = 0; eacc = '0;
        e_rd = 0; e_misp = 0; e_taken = 0; e_iqv = 0; e_ovf = 0;
        e_seq = '0; e_tag = '0; e_pc = '0; e_npc = '0;
        for (int k = 0; k < IW; k++) begin
            if (!stop) begin
                if (!v[k] || used == EXW) stop = 1;
                else begin
                    eacc[k] = 1'b1;
                    if (sb.size() < NPOS) sb.push_back({s[k], seq[k]});
                    else e_ovf = 1;
                    if (s[k]) x_sq++;
                    else begin
                        used++;
                        if (!m[k]) x_alu++;
                        else if (l[k]) x_ld++;
                        else if (t[k]) x_st++;
                        if (!found && mp[k]) begin
                            found = 1; e_rd = 1; e_misp = 1; e_taken = tk[k];
                            e_seq = seq[k]; e_pc = pc[k]; e_npc = npc[k];
                            if (pt[k]) x_ptk++;
                        end else if (!found && vi[k]) begin
                            found = 1; e_rd = 1; e_iqv = 1;
                            e_seq = seq[k]; e_npc = npc[k]; e_tag = vtag[k];
                            x_viol++;
                        end
                    end
                end
            end
        end
        run = 1;
        #1;
        chk("R2 R3 accept mask", 64'(acc), 64'(eacc));
        @(posedge clk);
        #3;
    endtask

    task automatic idle();
        drive(4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0);
    endtask

    // scoreboard monitor: commit lanes, redirect message, overflow
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (run) begin
                for (int c = 0; c < WP; c++) begin
                    if (sb.size() > 0) begin
                        chk("R4 commit valid", 64'(c_vld[c]), 64'd1);
                        chk("R4 commit entry", 64'({c_sq[c], c_seq[c]}), 64'(sb[0]));
                        void'(sb.pop_front());
                    end else begin
                        chk("R4 commit idle", 64'(c_vld[c]), 64'd0);
                    end
                end
                chk("R5 overflow flag", 64'(ovf), 64'(e_ovf));
                chk("R6 redirect valid", 64'(rd_vld), 64'(e_rd));
                chk("R8 iq notify valid", 64'(iqv_vld), 64'(e_iqv));
                if (e_rd) begin
                    chk("R7 R8 redirect seq", 64'(rd_seq), 64'(e_seq));
                    chk("R7 R8 redirect npc", 64'(rd_npc), 64'(e_npc));
                    chk("R7 R8 redirect pc", 64'(rd_pc), 64'(e_pc));
                    chk("R7 mispredict flag", 64'(rd_misp), 64'(e_misp));
                    chk("R7 taken bit", 64'(rd_taken), 64'(e_taken));
                end
                if (e_iqv) begin
                    chk("R8 notify seq", 64'(iqv_seq), 64'(e_seq));
                    chk("R8 notify tag", 64'(iqv_tag), 64'(e_tag));
                end
            end
        end
    end

    initial begin
        #(PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 commit", 64'(c_vld), 64'd0);
        chk("R1 redirect", 64'({rd_vld, iqv_vld, ovf}), 64'd0);
        chk("R1 counters", 64'({c_ld, c_st, c_alu, c_sqs}), 64'd0);
        chk("R1 counters2", 64'({c_viol, c_ptk}), 64'd0);
        rst_n = 1'b1;
        @(posedge clk);
        #3;
        // single ALU
        drive(4'b0001, 0, 0, 0, 0, 0, 0, 0, 0);
        // full group: execute limit R3
        drive(4'b1111, 0, 0, 0, 0, 0, 0, 0, 0);
        // squashed slots do not consume width R3
        drive(4'b1111, 4'b0101, 0, 0, 0, 0, 0, 0, 0);
        // hole stops scan R2
        drive(4'b1101, 0, 0, 0, 0, 0, 0, 0, 0);
        // loads and stores R9
        drive(4'b0111, 0, 4'b0111, 4'b0001, 4'b0010, 0, 0, 0, 0);
        // two mispredicts, first wins, taken R6 R7
        drive(4'b0111, 0, 0, 0, 0, 4'b0110, 4'b0110, 0, 4'b0010);
        // fall-through mispredict, taken 0 R7
        drive(4'b0111, 0, 0, 0, 0, 4'b0100, 0, 0, 0);
        // violation before mispredict R8 R6
        drive(4'b0011, 0, 4'b0001, 4'b0001, 0, 4'b0010, 4'b0010, 4'b0001, 4'b0010);
        // same slot: mispredict beats violation R6
        drive(4'b0001, 0, 0, 0, 0, 4'b0001, 0, 4'b0001, 4'b0001);
        // squashed mispredict ignored R6
        drive(4'b0011, 4'b0001, 0, 0, 0, 4'b0001, 4'b0001, 4'b0010, 0);
        // mispredict beyond execute limit ignored R6
        drive(4'b1111, 0, 0, 0, 0, 4'b1000, 4'b1000, 0, 4'b1000);
        idle();
        idle();
        idle();
        // fill writeback buffer until overflow R5
        for (int i = 0; i < 7; i++)
            drive(4'b1111, 4'b0001, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 7; i++)
            idle();
        // R9 counters
        chk("R9 loads", 64'(c_ld), 64'(x_ld));
        chk("R9 stores", 64'(c_st), 64'(x_st));
        chk("R9 alu", 64'(c_alu), 64'(x_alu));
        chk("R9 squashed", 64'(c_sqs), 64'(x_sq));
        chk("R9 violations", 64'(c_viol), 64'(x_viol));
        chk("R9 predicted taken", 64'(c_ptk), 64'(x_ptk));
        chk("R4 scoreboard drained", 64'(sb.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule